// File: doc/BRIEF.md
# GPIO Task and Event Channel Unit

This peripheral binds up to eight GPIO pins to channels that software steers through word-addressed registers. A channel is either off, in event mode or in task mode. In event mode it watches one input pin, detects a chosen transition after synchronization, and latches a sticky flag. When that flag meets its interrupt enable bit, the combined interrupt line rises.

In task mode the channel owns one output pin. The pin starts at a configured level when the channel enters task mode. Software then moves the pin by writing strobe registers: one forces high, one forces low, and one applies a configurable set, clear or toggle action. Interrupt enables change through a set register and a clear register, and both read back the current mask.

The register port is a single-cycle write strobe with a combinational read path. No data stream crosses the block edge, so no valid/ready handshake applies and nothing is ever back-pressured. Word addresses (6 bits at the default of 8 channels) are: high strobe 0x00+n, low strobe 0x08+n, action strobe 0x10+n, event flag 0x18+n, enable-set 0x20, enable-clear 0x21, channel setup 0x28+n.

Top module: `gpio_task_event`

## Requirements
- R1: After reset, every output enable, output level, interrupt, event flag, enable mask and setup register is 0.
- R2: A setup register keeps mode in bits [1:0] (01 event, 11 task, 00 or 10 off), pin index in bits [12:8], action/edge code in bits [17:16] and initial level in bit 20. It reads back exactly those fields, with all other bits 0.
- R3: Writing task mode to a channel that was not in task mode drives its pin (output enable 1) at the initial level. Rewriting setup while already in task mode keeps the present level.
- R4: A write with bit 0 = 1 to the high strobe (0x00+n) drives the pin high, and to the low strobe (0x08+n) drives it low, visible right after the write's clock edge. Bit 0 = 0 has no effect, and strobes to a channel not in task mode have no effect.
- R5: A write with bit 0 = 1 to the action strobe (0x10+n) applies the action code: 1 set, 2 clear, 3 toggle, 0 nothing.
- R6: Input pins pass two synchronizer flops. An edge matching the edge code (1 rising, 2 falling, 3 either) sets the flag, which is readable at 0x18+n in bit 0 after the third rising clock edge following the pin change and not before.
- R7: An event flag stays 1 until a write with bit 0 = 0 to its address. Writing 1 has no effect, and a new edge in the same cycle as a clearing write leaves the flag at 1.
- R8: Writing 1s to 0x20 enables the matching interrupt bits, and writing 1s to 0x21 disables them. Both addresses read the mask in bits [7:0]. The interrupt output is 1 while any channel has both its flag and its enable set.
- R9: A pin with no task-mode channel bound to it is undriven (output enable 0). When several task-mode channels share a pin, the lowest-numbered one sets its level.
- R10: Edge code 0, and any mode other than event, never sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (6) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| gpio_in | input | NUM_PINS (32) | Pin input levels |
| gpio_out | output | NUM_PINS (32) | Pin output levels |
| gpio_oe | output | NUM_PINS (32) | Pin output enables |
| irq | output | 1 | Combined channel interrupt |

## Verification
The bench aims at the event latency window. A design with a missing synchronizer stage flags one cycle early, and one with an extra stage flags one cycle late. It races a clearing write against a fresh edge, where a design with the wrong priority silently drops the event.

It rewrites task-mode setup to catch a design that reloads the initial level every time. It also binds two task channels to one pin to expose reversed priority. Strobes written with bit 0 clear, or sent to channels that are off, would move a pin in a design that decodes only the address. Edge codes "none" and the wrong polarity would raise flags in a design with loose edge decode.

// File: rtl/gte_pkg.sv
`timescale 1ns/1ps
package gte_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_EVT  = 2'd1,
    MODE_RSV  = 2'd2,
    MODE_TASK = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    GRP_HIGH = 3'd0,
    GRP_LOW  = 3'd1,
    GRP_ACT  = 3'd2,
    GRP_EVT  = 3'd3,
    GRP_EN   = 3'd4,
    GRP_CFG  = 3'd5
  } grp_e;

  // setup register field positions
  localparam int CFG_MODE_LSB = 0;
  localparam int CFG_PIN_LSB  = 8;
  localparam int CFG_PIN_FLD  = 5;
  localparam int CFG_ACT_LSB  = 16;
  localparam int CFG_INIT_BIT = 20;

  // action / edge codes
  localparam logic [1:0] ACT_NONE = 2'd0;
  localparam logic [1:0] ACT_SET  = 2'd1;  // rising edge in event mode
  localparam logic [1:0] ACT_CLR  = 2'd2;  // falling edge in event mode
  localparam logic [1:0] ACT_TGL  = 2'd3;  // any change in event mode
endpackage

// File: rtl/gte_in_sync.sv
`timescale 1ns/1ps
module gte_in_sync #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_raw,
  output logic [NUM_PINS-1:0] pin_cur,
  output logic [NUM_PINS-1:0] pin_prev
);
  logic [NUM_PINS-1:0] stage1_q, stage2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= pin_raw;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign pin_cur  = stage2_q;
  assign pin_prev = prev_q;
endmodule

// File: rtl/gte_channel.sv
`timescale 1ns/1ps
module gte_channel
  import gte_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int PIN_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [31:0]         wdata,
  input  logic                strobe_high,
  input  logic                strobe_low,
  input  logic                strobe_act,
  input  logic                flag_we,
  input  logic [NUM_PINS-1:0] pin_cur,
  input  logic [NUM_PINS-1:0] pin_prev,
  output logic [31:0]         cfg_rd,
  output logic                drive_en,
  output logic                evt_mode,
  output logic [PIN_W-1:0]    drive_pin,
  output logic                drive_lvl,
  output logic                flag
);
  mode_e            mode_q;
  logic [PIN_W-1:0] pin_q;
  logic [1:0]       act_q;
  logic             init_q;
  logic             lvl_q;
  logic             flag_q;

  mode_e            mode_new;
  logic             enter_task;
  logic             cur_b, prev_b, edge_hit;

  assign mode_new   = mode_e'(wdata[CFG_MODE_LSB +: 2]);
  assign enter_task = cfg_we && (mode_new == MODE_TASK) && (mode_q != MODE_TASK);

  // setup fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      pin_q  <= '0;
      act_q  <= ACT_NONE;
      init_q <= 1'b0;
    end else if (cfg_we) begin
      mode_q <= mode_new;
      pin_q  <= wdata[CFG_PIN_LSB +: PIN_W];
      act_q  <= wdata[CFG_ACT_LSB +: 2];
      init_q <= wdata[CFG_INIT_BIT];
    end
  end

  // output level: low beats high beats action
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else if (enter_task) begin
      lvl_q <= wdata[CFG_INIT_BIT];
    end else if (mode_q == MODE_TASK) begin
      if (strobe_low) begin
        lvl_q <= 1'b0;
      end else if (strobe_high) begin
        lvl_q <= 1'b1;
      end else if (strobe_act) begin
        unique case (act_q)
          ACT_SET:  lvl_q <= 1'b1;
          ACT_CLR:  lvl_q <= 1'b0;
          ACT_TGL:  lvl_q <= ~lvl_q;
          default:  lvl_q <= lvl_q;
        endcase
      end
    end
  end

  // edge detection on the synchronized pin
  assign cur_b  = pin_cur[pin_q];
  assign prev_b = pin_prev[pin_q];

  always_comb begin
    edge_hit = 1'b0;
    if (mode_q == MODE_EVT) begin
      unique case (act_q)
        ACT_SET: edge_hit = cur_b & ~prev_b;
        ACT_CLR: edge_hit = ~cur_b & prev_b;
        ACT_TGL: edge_hit = cur_b ^ prev_b;
        default: edge_hit = 1'b0;
      endcase
    end
  end

  // sticky flag: a new edge outranks a clearing write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            flag_q <= 1'b0;
    else if (edge_hit)     flag_q <= 1'b1;
    else if (flag_we && !wdata[0]) flag_q <= 1'b0;
  end

  always_comb begin
    cfg_rd = '0;
    cfg_rd[CFG_MODE_LSB +: 2]   = mode_q;
    cfg_rd[CFG_PIN_LSB +: PIN_W] = pin_q;
    cfg_rd[CFG_ACT_LSB +: 2]    = act_q;
    cfg_rd[CFG_INIT_BIT]        = init_q;
  end

  assign drive_en  = (mode_q == MODE_TASK);
  assign evt_mode  = (mode_q == MODE_EVT);
  assign drive_pin = pin_q;
  assign drive_lvl = lvl_q;
  assign flag      = flag_q;
endmodule

// File: rtl/gte_pin_mux.sv
`timescale 1ns/1ps
module gte_pin_mux #(
  parameter int NUM_CH   = 8,
  parameter int NUM_PINS = 32,
  parameter int PIN_W    = 5
) (
  input  logic [NUM_CH-1:0]             ch_en,
  input  logic [NUM_CH-1:0][PIN_W-1:0]  ch_pin,
  input  logic [NUM_CH-1:0]             ch_lvl,
  output logic [NUM_PINS-1:0]           pin_out,
  output logic [NUM_PINS-1:0]           pin_oe
);
  // walk from the highest channel down so the lowest index wins
  always_comb begin
    pin_out = '0;
    pin_oe  = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (ch_en[c]) begin
        pin_oe[ch_pin[c]]  = 1'b1;
        pin_out[ch_pin[c]] = ch_lvl[c];
      end
    end
  end
endmodule

// File: rtl/gpio_task_event.sv
`timescale 1ns/1ps
module gpio_task_event
  import gte_pkg::*;
#(
  parameter  int NUM_CH   = 8,
  parameter  int NUM_PINS = 32,
  localparam int PIN_W    = $clog2(NUM_PINS),
  localparam int CH_AW    = $clog2(NUM_CH),
  localparam int ADDR_W   = CH_AW + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] gpio_in,
  output logic [NUM_PINS-1:0] gpio_out,
  output logic [NUM_PINS-1:0] gpio_oe,
  output logic                irq
);
  grp_e                      grp;
  logic [CH_AW-1:0]          ch_idx;
  logic [NUM_PINS-1:0]       pin_cur, pin_prev;
  logic [NUM_CH-1:0]         task_mode, evt_mode, ch_lvl, evt_flag;
  logic [NUM_CH-1:0][PIN_W-1:0] ch_pin;
  logic [31:0]               cfg_rd [NUM_CH];
  logic [NUM_CH-1:0]         en_q;
  logic                      wr_en_set, wr_en_clr;

  assign grp    = grp_e'(bus_addr[ADDR_W-1:CH_AW]);
  assign ch_idx = bus_addr[CH_AW-1:0];

  gte_in_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_raw  (gpio_in),
    .pin_cur  (pin_cur),
    .pin_prev (pin_prev)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel = bus_we && (ch_idx == CH_AW'(c));

    gte_channel #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (sel && grp == GRP_CFG),
      .wdata       (bus_wdata),
      .strobe_high (sel && grp == GRP_HIGH && bus_wdata[0]),
      .strobe_low  (sel && grp == GRP_LOW  && bus_wdata[0]),
      .strobe_act  (sel && grp == GRP_ACT  && bus_wdata[0]),
      .flag_we     (sel && grp == GRP_EVT),
      .pin_cur     (pin_cur),
      .pin_prev    (pin_prev),
      .cfg_rd      (cfg_rd[c]),
      .drive_en    (task_mode[c]),
      .evt_mode    (evt_mode[c]),
      .drive_pin   (ch_pin[c]),
      .drive_lvl   (ch_lvl[c]),
      .flag        (evt_flag[c])
    );
  end

  gte_pin_mux #(.NUM_CH(NUM_CH), .NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_mux (
    .ch_en   (task_mode),
    .ch_pin  (ch_pin),
    .ch_lvl  (ch_lvl),
    .pin_out (gpio_out),
    .pin_oe  (gpio_oe)
  );

  // interrupt enable mask
  assign wr_en_set = bus_we && grp == GRP_EN && ch_idx == CH_AW'(0);
  assign wr_en_clr = bus_we && grp == GRP_EN && ch_idx == CH_AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= '0;
    else if (wr_en_set) en_q <= en_q | bus_wdata[NUM_CH-1:0];
    else if (wr_en_clr) en_q <= en_q & ~bus_wdata[NUM_CH-1:0];
  end

  assign irq = |(evt_flag & en_q);

  // read path
  always_comb begin
    bus_rdata = '0;
    unique case (grp)
      GRP_EVT: bus_rdata[0] = evt_flag[ch_idx];
      GRP_EN:  if (ch_idx <= CH_AW'(1)) bus_rdata[NUM_CH-1:0] = en_q;
      GRP_CFG: bus_rdata = cfg_rd[ch_idx];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_task_event_chk.sv
`timescale 1ns/1ps
module gpio_task_event_chk #(
  parameter int NUM_CH   = 8,
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [NUM_CH-1:0]   evt_flag,
  input logic [NUM_CH-1:0]   evt_mode,
  input logic [NUM_CH-1:0]   task_mode,
  input logic [NUM_CH-1:0]   en_q,
  input logic [NUM_PINS-1:0] gpio_oe,
  input logic                irq
);
  localparam int CH_AW = ADDR_W - 3;
  localparam logic [2:0] G_EVT = 3'd3;
  localparam logic [2:0] G_EN  = 3'd4;

  logic en_set_wr, en_clr_wr;
  assign en_set_wr = bus_we && bus_addr == {G_EN, CH_AW'(0)};
  assign en_clr_wr = bus_we && bus_addr == {G_EN, CH_AW'(1)};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    // R7: flag survives everything but a clearing write
    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      evt_flag[c] && !(bus_we && bus_addr == {G_EVT, CH_AW'(c)} && !bus_wdata[0])
      |=> evt_flag[c]);
    // R10: a flag only rises while its channel is in event mode
    assert_flag_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_flag[c]) |-> $past(evt_mode[c]));
  end

  assert_en_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_wr |=> ((en_q & $past(bus_wdata[NUM_CH-1:0])) == $past(bus_wdata[NUM_CH-1:0])));

  assert_en_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_wr |=> ((en_q & $past(bus_wdata[NUM_CH-1:0])) == '0));

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_flag != '0 && en_q != '0));

  assert_oe_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gpio_oe) <= $countones(task_mode));
endmodule

bind gpio_task_event gpio_task_event_chk #(
  .NUM_CH(NUM_CH), .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .evt_flag  (evt_flag),
  .evt_mode  (evt_mode),
  .task_mode (task_mode),
  .en_q      (en_q),
  .gpio_oe   (gpio_oe),
  .irq       (irq)
);

// File: tb/test_gpio_task_event.sv
`timescale 1ns/1ps
module test_gpio_task_event;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] gpio_in = '0;
  logic [31:0] gpio_out, gpio_oe;
  logic        irq;

  always #2.5 clk = ~clk;

  gpio_task_event i_gpio_task_event (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq)
  );

  typedef struct {
    int          kind;   // 0 register, 1 out bit, 2 oe bit, 3 irq
    int          idx;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int pushed = 0, popped = 0, checks = 0, fails = 0;

  function automatic logic [31:0] cfgv(int mode, int pin, int act, int init);
    return 32'(mode) | (32'(pin) << 8) | (32'(act) << 16) | (32'(init) << 20);
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic push(input int kind, input int idx, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
    q.push_back(it);
    pushed++;
    wait (popped == pushed);
  endtask

  task automatic chk_reg(input logic [5:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    push(0, 0, exp, tag);
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    item_t it;
    logic [31:0] act;
    forever begin
      wait (pushed > popped);
      #1;
      while (q.size() > 0) begin
        it = q.pop_front();
        case (it.kind)
          0: act = bus_rdata;
          1: act = {31'b0, gpio_out[it.idx]};
          2: act = {31'b0, gpio_oe[it.idx]};
          default: act = {31'b0, irq};
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
        popped++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_reg(6'h18, 0, "R1 event flag 0");
    chk_reg(6'h20, 0, "R1 enable mask");
    chk_reg(6'h28, 0, "R1 setup ch0");
    bus_addr = 6'h00;
    push(0, 0, 0, "R1 task strobe reads 0");
    if (gpio_oe !== 0 || gpio_out !== 0) begin
      fails++; $display("FAIL R1 pins actual=%h/%h expected=0/0", gpio_oe, gpio_out);
    end
    checks++;
    push(3, 0, 0, "R1 irq low");

    // R2 field readback, junk bits dropped
    wr(6'h28, cfgv(3, 3, 3, 1));
    chk_reg(6'h28, 32'h0013_0303, "R2 setup ch0 readback");
    wr(6'h2F, 32'hFFFF_FFFF);
    chk_reg(6'h2F, 32'h0013_1F03, "R2 masked readback ch7");
    push(2, 31, 1, "R3 ch7 drives pin 31");
    push(1, 31, 1, "R3 ch7 initial level 1");
    wr(6'h2F, 0);
    push(2, 31, 0, "R9 pin 31 released");

    // R3 task entry on ch0 pin3
    push(2, 3, 1, "R3 oe pin3");
    push(1, 3, 1, "R3 init level pin3");

    // R4 high/low strobes
    wr(6'h08, 1);
    push(1, 3, 0, "R4 low strobe");
    wr(6'h00, 0);
    push(1, 3, 0, "R4 high strobe with bit0=0 ignored");
    wr(6'h00, 1);
    push(1, 3, 1, "R4 high strobe");

    // R5 toggle action
    wr(6'h10, 1);
    push(1, 3, 0, "R5 toggle to 0");
    wr(6'h10, 1);
    push(1, 3, 1, "R5 toggle to 1");

    // R3 rewrite while in task mode keeps level
    wr(6'h28, cfgv(3, 3, 1, 0));
    push(1, 3, 1, "R3 level kept on rewrite");
    wr(6'h08, 1);
    wr(6'h10, 1);
    push(1, 3, 1, "R5 set action");
    wr(6'h28, cfgv(3, 3, 2, 0));
    wr(6'h10, 1);
    push(1, 3, 0, "R5 clear action");
    wr(6'h28, cfgv(3, 3, 0, 0));
    wr(6'h00, 1);
    wr(6'h10, 1);
    push(1, 3, 1, "R5 action none leaves level");

    // R9 shared pin: lower channel wins
    wr(6'h29, cfgv(3, 3, 0, 0));
    push(1, 3, 1, "R9 ch0 wins over ch1");
    wr(6'h28, 0);
    push(1, 3, 0, "R9 ch1 takes pin after ch0 off");
    push(2, 3, 1, "R9 pin still driven");
    wr(6'h29, 0);
    push(2, 3, 0, "R9 pin released");

    // R4 strobe to an off channel
    wr(6'h02, 1);
    wr(6'h12, 1);
    chk_reg(6'h2A, 0, "R4 off channel unchanged");
    push(2, 0, 0, "R4 off channel does not drive");

    // R6 rising edge latency on ch4 pin7
    wr(6'h2C, cfgv(1, 7, 1, 0));
    @(negedge clk); gpio_in[7] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk_reg(6'h1C, 0, "R6 flag not yet set after two edges");
    @(posedge clk); @(negedge clk);
    chk_reg(6'h1C, 1, "R6 flag set after third edge");
    push(3, 0, 0, "R8 irq masked");
    wr(6'h20, 32'h10);
    push(3, 0, 1, "R8 irq with enable");
    chk_reg(6'h20, 32'h10, "R8 enable-set reads mask");
    chk_reg(6'h21, 32'h10, "R8 enable-clear reads mask");

    // R7 clear and write-1
    wr(6'h1C, 0);
    chk_reg(6'h1C, 0, "R7 cleared by writing 0");
    push(3, 0, 0, "R8 irq drops with flag");
    @(negedge clk); gpio_in[7] = 1'b0;
    repeat (4) @(negedge clk);
    chk_reg(6'h1C, 0, "R6 falling ignored in rising mode");
    wr(6'h1C, 1);
    chk_reg(6'h1C, 0, "R7 writing 1 does not set");
    @(negedge clk); gpio_in[7] = 1'b1;
    repeat (4) @(negedge clk);
    wr(6'h1C, 1);
    chk_reg(6'h1C, 1, "R7 writing 1 does not clear");
    push(3, 0, 1, "R8 irq high again");
    wr(6'h21, 32'h10);
    push(3, 0, 0, "R8 disabled");
    chk_reg(6'h20, 0, "R8 mask cleared");

    // R6 any-change and R10 edge code none on pin 9
    wr(6'h2D, cfgv(1, 9, 3, 0));
    wr(6'h2E, cfgv(1, 9, 0, 0));
    wr(6'h2B, cfgv(0, 9, 3, 0));
    @(negedge clk); gpio_in[9] = 1'b1;
    repeat (4) @(negedge clk);
    chk_reg(6'h1D, 1, "R6 any-change rising");
    chk_reg(6'h1E, 0, "R10 edge code none");
    chk_reg(6'h1B, 0, "R10 off channel no flag");
    wr(6'h1D, 0);
    @(negedge clk); gpio_in[9] = 1'b0;
    repeat (4) @(negedge clk);
    chk_reg(6'h1D, 1, "R6 any-change falling");

    // R7 edge and clearing write in the same cycle
    wr(6'h1D, 0);
    chk_reg(6'h1D, 0, "R7 cleared before race");
    @(negedge clk); gpio_in[9] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_we = 1'b1; bus_addr = 6'h1D; bus_wdata = 0;
    @(negedge clk); bus_we = 1'b0;
    chk_reg(6'h1D, 1, "R7 edge wins over clear");

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule